// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Interface

This block is the digital control side of a four-channel, 12-bit converter. Each channel has two register ranks. The first rank is an input register that the host writes and can read back. The second rank is an output register that stands for the code driving that channel's analog stage. The host selects one channel with a 2-bit address. It controls each access with an active-low chip select, a read/write level and an active-low load strobe.

Every strobe is sampled on the rising edge of the system clock. A write loads only the addressed input register. A write with load held low also loads the addressed output register, so both ranks pass the bus value straight through. With chip select high, a low load copies every input register into its own output register in one edge, which updates all channels together. The bidirectional data bus is split into a write-data port and a registered read-data port, plus an output-enable that stands in for the bus driver.

A synchronous active-high reset returns every register to the midscale code 12'h800, whatever chip select and load are doing.

Top module: `dac_quad_regs`

## Requirements
- R1: Address 2'b00 selects channel A, 2'b01 selects B, 2'b10 selects C and 2'b11 selects D. Channel k's output code sits at out_codes[12k+11:12k], with bit 11 as the MSB. At most one channel is selected in any cycle.
- R2: While cs_n is 1, no input register changes and rdata_oe is 0 in the next cycle.
- R3: With cs_n=0, rd_wr=0 and ld_n=1, the addressed input register takes wdata at the clock edge. No output register changes.
- R4: With cs_n=0, rd_wr=0 and ld_n=0, both the input and output registers of the addressed channel take wdata at the edge. The other output registers hold.
- R5: With cs_n=0, rd_wr=1 and ld_n=1, in the next cycle rdata equals the addressed input register's value from before the edge, and rdata_oe is 1. No register changes.
- R6: With cs_n=0, rd_wr=1 and ld_n=0, the block performs the same read as R5. No input or output register changes.
- R7: With cs_n=1 and ld_n=0, every output register takes the value of its own input register at the edge.
- R8: With rst=1 at an edge, every input and output register becomes 12'h800 and rdata_oe becomes 0, regardless of cs_n, rd_wr and ld_n.
- R9: rdata_oe is 1 only in the cycle after a read (cs_n=0, rd_wr=1). In every other cycle it is 0 and rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to midscale |
| cs_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ld_n | input | 1 | Active-low load / update strobe |
| addr | input | 2 | Channel select |
| wdata | input | 12 | Write data from the bus |
| rdata | output | 12 | Registered readback data |
| rdata_oe | output | 1 | Bus drive enable for readback |
| out_codes | output | 48 | Four output-register codes, channel A in the low bits |

## Verification
The bench targets the strobe combinations that look alike but must act differently. A read with load low must not update any output, because a decoder that gives load priority would update the outputs there. A transparent write must touch only the addressed output, and a decoder that broadcasts would change the other three. An update with chip select high must copy all four channels in the same edge, so a copy done through the address mux would update only one. The bench also asserts reset in the middle of traffic with the strobes active, and it checks readback of an unselected input register after a write, which catches decode aliasing between channels.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WRITE,
    OP_XPARENT,
    OP_READ,
    OP_READ_NOLD,
    OP_BCAST
  } op_e;
endpackage

// File: rtl/dacq_decode.sv
module dacq_decode
  import dacq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = $clog2(NCH)
) (
  input  logic           cs_n,
  input  logic           rd_wr,
  input  logic           ld_n,
  input  logic [AW-1:0]  addr,
  output op_e            op,
  output logic [NCH-1:0] sel
);
  always_comb begin
    op = OP_IDLE;
    if (cs_n) begin
      if (!ld_n) op = OP_BCAST;
    end else if (rd_wr) begin
      op = ld_n ? OP_READ : OP_READ_NOLD;
    end else begin
      op = ld_n ? OP_WRITE : OP_XPARENT;
    end
  end

  always_comb begin
    sel = '0;
    if (!cs_n) sel[addr] = 1'b1;
  end
endmodule

// File: rtl/dacq_channel.sv
module dacq_channel #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_in,
  input  logic          wr_out,
  input  logic          bcast,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] out_q
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= MID;
      out_q <= MID;
    end else begin
      if (wr_in) in_q <= wdata;
      if (wr_out) out_q <= wdata;
      else if (bcast) out_q <= in_q;
    end
  end
endmodule

// File: rtl/dacq_readback.sv
module dacq_readback #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter int AW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [NCH*DW-1:0] in_flat,
  output logic [DW-1:0]     rdata,
  output logic              rdata_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else if (rd_en) begin
      rdata    <= in_flat[addr*DW +: DW];
      rdata_oe <= 1'b1;
    end else begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_quad_regs.sv
module dac_quad_regs
  import dacq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter int AW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic              ld_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdata_oe,
  output logic [NCH*DW-1:0] out_codes
);
  op_e              op;
  logic [NCH-1:0]   wr_sel;
  logic [NCH*DW-1:0] in_flat;
  logic             is_write, is_xparent, is_bcast, is_read;

  dacq_decode #(.NCH(NCH), .AW(AW)) dec_i (
    .cs_n(cs_n), .rd_wr(rd_wr), .ld_n(ld_n), .addr(addr),
    .op(op), .sel(wr_sel)
  );

  assign is_write   = (op == OP_WRITE) || (op == OP_XPARENT);
  assign is_xparent = (op == OP_XPARENT);
  assign is_bcast   = (op == OP_BCAST);
  assign is_read    = (op == OP_READ) || (op == OP_READ_NOLD);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dacq_channel #(.DW(DW)) ch_i (
      .clk   (clk),
      .rst   (rst),
      .wr_in (is_write && wr_sel[k]),
      .wr_out(is_xparent && wr_sel[k]),
      .bcast (is_bcast),
      .wdata (wdata),
      .in_q  (in_flat[k*DW +: DW]),
      .out_q (out_codes[k*DW +: DW])
    );
  end

  dacq_readback #(.NCH(NCH), .DW(DW), .AW(AW)) rb_i (
    .clk(clk), .rst(rst), .rd_en(is_read), .addr(addr),
    .in_flat(in_flat), .rdata(rdata), .rdata_oe(rdata_oe)
  );
endmodule

// File: rtl/dac_quad_regs_chk.sv
module dac_quad_regs_chk #(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_wr,
  input logic              ld_n,
  input logic              rdata_oe,
  input logic [NCH*DW-1:0] out_codes,
  input logic [NCH*DW-1:0] in_flat,
  input logic [NCH-1:0]    wr_sel
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && ld_n) |=> ($stable(out_codes) && $stable(in_flat) && !rdata_oe));

  // R6
  read_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && rd_wr) |=> ($stable(out_codes) && $stable(in_flat)));

  // R7
  bcast_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !ld_n) |=> (out_codes == $past(in_flat)));

  // R9
  oe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(!cs_n && rd_wr));

  // R8
  reset_mid_chk: assert property (@(posedge clk)
    rst |=> (out_codes == {NCH{MID}} && in_flat == {NCH{MID}} && !rdata_oe));
endmodule

bind dac_quad_regs dac_quad_regs_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_wr(rd_wr), .ld_n(ld_n),
  .rdata_oe(rdata_oe), .out_codes(out_codes), .in_flat(in_flat),
  .wr_sel(wr_sel)
);

// File: tb/dac_quad_regs_tb.sv
module dac_quad_regs_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int AW  = 2;
  localparam logic [DW-1:0] MID = 12'h800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_wr = 1'b0, ld_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;
  logic [NCH*DW-1:0] out_codes;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW-1:0] m_in [NCH];
  logic [DW-1:0] m_out [NCH];
  logic [DW-1:0] m_rdata;
  logic m_oe;

  always #2.5 clk = ~clk;

  dac_quad_regs #(.NCH(NCH), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_wr(rd_wr), .ld_n(ld_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .out_codes(out_codes)
  );

  function automatic string req_of(logic r, logic c, logic w, logic l);
    if (r) return "R8";
    if (c) return l ? "R2" : "R7";
    if (w) return l ? "R5" : "R6";
    return l ? "R3" : "R4";
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(logic r, logic c, logic w, logic l, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] old_in [NCH];
    for (int k = 0; k < NCH; k++) old_in[k] = m_in[k];
    if (r) begin
      for (int k = 0; k < NCH; k++) begin m_in[k] = MID; m_out[k] = MID; end
      m_oe = 0; m_rdata = '0;
    end else begin
      m_oe = !c && w;
      m_rdata = m_oe ? old_in[a] : '0;
      if (!c && !w) begin
        m_in[a] = d;
        if (!l) m_out[a] = d;
      end
      if (c && !l)
        for (int k = 0; k < NCH; k++) m_out[k] = old_in[k];
    end
  endtask

  task automatic step(logic r, logic c, logic w, logic l, logic [AW-1:0] a, logic [DW-1:0] d);
    string tag;
    @(negedge clk);
    rst = r; cs_n = c; rd_wr = w; ld_n = l; addr = a; wdata = d;
    model(r, c, w, l, a, d);
    tag = req_of(r, c, w, l);
    @(posedge clk); #1;
    for (int k = 0; k < NCH; k++)
      check(tag, out_codes[k*DW +: DW], m_out[k], $sformatf("R1 out ch%0d", k));
    check((m_oe ? tag : "R9"), {11'd0, rdata_oe}, {11'd0, m_oe}, "oe");
    check((m_oe ? tag : "R9"), rdata, m_rdata, "rdata");
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin m_in[k] = MID; m_out[k] = MID; end
    m_oe = 0; m_rdata = '0;
    void'($urandom(32'd4242));
    // R8: reset state
    step(1, 0, 0, 0, 2'd1, 12'h123);
    step(1, 1, 1, 1, 2'd0, 12'h000);
    // R3 / R1: write each channel with distinct value, outputs hold
    for (int k = 0; k < NCH; k++) step(0, 0, 0, 1, k[AW-1:0], 12'h100 * k[DW-1:0] + 12'h0A5);
    // R5: read back each channel
    for (int k = 0; k < NCH; k++) step(0, 0, 1, 1, k[AW-1:0], 12'hFFF);
    // R7: broadcast
    step(0, 1, 0, 0, 2'd0, 12'h000);
    // R4: transparent on C only
    step(0, 0, 0, 0, 2'd2, 12'hFFF);
    step(0, 0, 0, 1, 2'd0, 12'h001);
    // R6: read with load low, no output update
    step(0, 0, 1, 0, 2'd0, 12'h777);
    // R2: cs high, writes ignored, then readback proves it
    step(0, 1, 0, 1, 2'd3, 12'h0F0);
    step(0, 0, 1, 1, 2'd3, 12'h000);
    // R8: reset mid-traffic with strobes active
    step(1, 0, 0, 0, 2'd3, 12'hABC);
    step(0, 0, 1, 1, 2'd3, 12'h000);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step((rv[31:26] == 6'd0), rv[0], rv[1], rv[2], rv[4:3], rv[16:5]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule